// File: doc/BRIEF.md
# GGA Sentence UTC Time Extractor

This block watches a stream of ASCII characters coming from a GPS receiver's serial link. It finds the start of each positioning sentence and checks that the sentence is a GGA fix report from a GPS talker. It then picks the UTC time out of the first field and checks the hexadecimal XOR checksum at the end of the sentence. The time reaches the outputs only after the checksum has matched and the line terminator has arrived. Until then the digits wait in a staging register. A sentence that is malformed, too long or cut short never changes the published time.

Characters arrive one per cycle on a valid/ready byte interface, usually from a UART receiver. The block never stalls, so its ready output is held high. The results are a set of BCD time fields, a single-cycle `time_valid` strobe and a single-cycle `cksum_err` strobe.

Top module: `gga_time_extractor`

## Requirements
- R1: While reset is held and just after it, all time outputs are zero, `time_valid` and `cksum_err` are low, and `in_ready` is high.
- R2: A sentence of the form `$GPGGA,hhmmss.sss,...*XY<CR><LF>` whose checksum matches pulses `time_valid` for one cycle, in the cycle after the LF byte is accepted. In that same cycle `time_hh`, `time_mm` and `time_ss` each hold two BCD digits, with the tens digit in bits [7:4]. `time_ms` holds three BCD digits, with the hundreds digit in bits [11:8].
- R3: The checksum is the XOR of every byte strictly between `$` and `*`. It is compared with the two hex digits after `*`, high nibble first. On a mismatch, `cksum_err` pulses in the cycle after the LF and the time outputs keep their previous values.
- R4: The checksum digits are accepted as 0-9, A-F and a-f.
- R5: A checksum character that is not a hex digit pulses `cksum_err` in the cycle after it is accepted. The block then drops the sentence and leaves the time unchanged.
- R6: A sentence whose identifier is not exactly `GPGGA` followed by a comma produces neither strobe and does not change the time.
- R7: A non-digit byte in one of the nine digit positions of the time field, or a byte other than `.` in its seventh position, drops the sentence silently.
- R8: A `$` that is accepted at any point restarts parsing. The new sentence decodes normally.
- R9: A sentence may be at most 82 characters long, counting from `$` through LF. If an accepted byte would be the 83rd character, `cksum_err` pulses in the next cycle and the sentence is dropped.
- R10: If the checksum is followed by anything other than CR and then LF, the sentence is dropped with no strobe.
- R11: A byte presented while `in_valid` is low is ignored, even if it is `$`.
- R12: `time_valid` and `cksum_err` are never high in the same cycle, and each stays high for only one cycle at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | ASCII byte from the serial receiver |
| in_valid | input | 1 | `in_data` holds a byte |
| in_ready | output | 1 | Byte accepted (always high) |
| time_hh | output | 8 | Hours, two BCD digits |
| time_mm | output | 8 | Minutes, two BCD digits |
| time_ss | output | 8 | Seconds, two BCD digits |
| time_ms | output | 12 | Milliseconds, three BCD digits |
| time_valid | output | 1 | One-cycle strobe when a new time is published |
| cksum_err | output | 1 | One-cycle strobe on a checksum, hex or length fault |

## Verification
Every result is registered exactly once. The time outputs and `time_valid` therefore change on the clock edge that accepts the LF. `cksum_err` is raised on the edge that accepts the LF (for a mismatch), the bad hex character, or the 83rd character. The bench drives each byte at a falling edge and drops `in_valid` at the next falling edge, so that edge falls just after the accepting edge. Each strobe and time field is compared at that point. Strobe counters sampled at every falling edge confirm that dropped sentences raise nothing later.

// File: rtl/nmea_pkg.sv
package nmea_pkg;

   typedef enum logic [3:0] {
      PS_IDLE,
      PS_IDENT,
      PS_TIME,
      PS_FIELDS,
      PS_SUM_HI,
      PS_SUM_LO,
      PS_EXP_CR,
      PS_EXP_LF,
      PS_DISCARD
   } parse_state_t;

   localparam logic [7:0] CH_START = 8'h24;  // '$'
   localparam logic [7:0] CH_COMMA = 8'h2C;
   localparam logic [7:0] CH_DOT   = 8'h2E;
   localparam logic [7:0] CH_STAR  = 8'h2A;
   localparam logic [7:0] CH_CR    = 8'h0D;
   localparam logic [7:0] CH_LF    = 8'h0A;

   localparam int TIME_CHARS = 10;
   localparam int DOT_POS    = 6;
   localparam int TIME_DIGITS = 9;

   function automatic logic is_dec(input logic [7:0] c);
      return (c >= 8'h30) && (c <= 8'h39);
   endfunction

endpackage

// File: rtl/nmea_hex_nibble.sv
module nmea_hex_nibble #(
   parameter bit ALLOW_LOWER = 1'b1
) (
   input  logic [7:0] ch,
   output logic       is_hex,
   output logic [3:0] nib
);
   logic dig, up, lo;

   assign dig = (ch >= 8'h30) && (ch <= 8'h39);
   assign up  = (ch >= 8'h41) && (ch <= 8'h46);

   generate
      if (ALLOW_LOWER) begin : g_lower
         assign lo = (ch >= 8'h61) && (ch <= 8'h66);
      end else begin : g_upper_only
         assign lo = 1'b0;
      end
   endgenerate

   assign is_hex = dig | up | lo;
   assign nib    = dig ? ch[3:0] : (ch[3:0] + 4'd9);
endmodule

// File: rtl/nmea_id_match.sv
module nmea_id_match #(
   parameter int                  ID_LEN = 5,
   parameter logic [8*ID_LEN-1:0] ID_STR = "GPGGA",
   localparam int                 IDX_W  = $clog2(ID_LEN + 1)
) (
   input  logic [7:0]       ch,
   input  logic [IDX_W-1:0] idx,
   output logic             hit
);
   logic [ID_LEN-1:0] pos_hit;

   generate
      for (genvar g = 0; g < ID_LEN; g++) begin : g_pos
         assign pos_hit[g] = (ch == ID_STR[8*(ID_LEN-1-g) +: 8]);
      end
   endgenerate

   always_comb begin
      hit = 1'b0;
      for (int k = 0; k < ID_LEN; k++)
         if (idx == IDX_W'(k)) hit = pos_hit[k];
   end
endmodule

// File: rtl/nmea_time_stage.sv
module nmea_time_stage #(
   parameter  int DIGITS = 9,
   localparam int STG_W  = 4 * DIGITS
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        shift_en,
   input  logic [3:0]  digit,
   input  logic        commit,
   output logic [7:0]  hh,
   output logic [7:0]  mm,
   output logic [7:0]  ss,
   output logic [11:0] ms
);
   logic [STG_W-1:0] stage_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_q <= '0;
         hh <= '0;
         mm <= '0;
         ss <= '0;
         ms <= '0;
      end else begin
         if (shift_en) stage_q <= {stage_q[STG_W-5:0], digit};
         if (commit) begin
            hh <= stage_q[35:28];
            mm <= stage_q[27:20];
            ss <= stage_q[19:12];
            ms <= stage_q[11:0];
         end
      end
   end
endmodule

// File: rtl/gga_time_extractor.sv
module gga_time_extractor
   import nmea_pkg::*;
#(
   parameter int MAX_LEN         = 82,
   parameter bit ALLOW_LOWER_HEX = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [7:0]  in_data,
   input  logic        in_valid,
   output logic        in_ready,
   output logic [7:0]  time_hh,
   output logic [7:0]  time_mm,
   output logic [7:0]  time_ss,
   output logic [11:0] time_ms,
   output logic        time_valid,
   output logic        cksum_err
);
   localparam int ID_LEN = 5;
   localparam int IDX_W  = $clog2(ID_LEN + 1);
   localparam int LEN_W  = $clog2(MAX_LEN + 1);
   localparam int MIN_LEN = 1 + ID_LEN + 1 + TIME_CHARS + 1 + 2 + 2;

   generate
      if (MAX_LEN < MIN_LEN) begin : g_bad_len
         $error("MAX_LEN too small to hold a minimal sentence");
      end
   endgenerate

   parse_state_t   st_q;
   logic [3:0]     pos_q;
   logic [7:0]     xsum_q;
   logic [LEN_W-1:0] len_q;
   logic [3:0]     sum_hi_q;
   logic           tv_q, err_q;

   logic           acc, active, id_hit, hex_ok;
   logic [3:0]     hex_nib;
   logic           shift_en, commit;

   assign in_ready = 1'b1;
   assign acc      = in_valid;
   assign active   = (st_q != PS_IDLE) && (st_q != PS_DISCARD);

   nmea_id_match #(.ID_LEN(ID_LEN), .ID_STR("GPGGA")) u_id (
      .ch (in_data),
      .idx(pos_q[IDX_W-1:0]),
      .hit(id_hit)
   );

   nmea_hex_nibble #(.ALLOW_LOWER(ALLOW_LOWER_HEX)) u_hex (
      .ch    (in_data),
      .is_hex(hex_ok),
      .nib   (hex_nib)
   );

   assign shift_en = acc && (in_data != CH_START) && (st_q == PS_TIME) &&
                     (len_q != LEN_W'(MAX_LEN)) &&
                     (pos_q != 4'(DOT_POS)) && is_dec(in_data);

   assign commit = acc && (st_q == PS_EXP_LF) && (in_data == CH_LF) &&
                   (len_q != LEN_W'(MAX_LEN)) &&
                   ({sum_hi_q, hex_nib_lo_q()} == xsum_q);

   logic [3:0] sum_lo_q;
   function automatic logic [3:0] hex_nib_lo_q();
      return sum_lo_q;
   endfunction

   nmea_time_stage #(.DIGITS(TIME_DIGITS)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_en(shift_en),
      .digit   (in_data[3:0]),
      .commit  (commit),
      .hh      (time_hh),
      .mm      (time_mm),
      .ss      (time_ss),
      .ms      (time_ms)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= PS_IDLE;
         pos_q    <= '0;
         xsum_q   <= '0;
         len_q    <= '0;
         sum_hi_q <= '0;
         sum_lo_q <= '0;
         tv_q     <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         tv_q  <= 1'b0;
         err_q <= 1'b0;
         if (acc) begin
            if (in_data == CH_START) begin
               st_q   <= PS_IDENT;
               pos_q  <= '0;
               xsum_q <= '0;
               len_q  <= LEN_W'(1);
            end else if (active && (len_q == LEN_W'(MAX_LEN))) begin
               err_q <= 1'b1;
               st_q  <= PS_DISCARD;
            end else begin
               if (active) len_q <= len_q + 1'b1;
               unique case (st_q)
                  PS_IDENT: begin
                     xsum_q <= xsum_q ^ in_data;
                     if (pos_q < 4'(ID_LEN)) begin
                        if (id_hit) pos_q <= pos_q + 4'd1;
                        else        st_q  <= PS_DISCARD;
                     end else if (in_data == CH_COMMA) begin
                        st_q  <= PS_TIME;
                        pos_q <= '0;
                     end else begin
                        st_q <= PS_DISCARD;
                     end
                  end
                  PS_TIME: begin
                     xsum_q <= xsum_q ^ in_data;
                     if ((pos_q == 4'(DOT_POS)) ? (in_data != CH_DOT)
                                                : !is_dec(in_data)) begin
                        st_q <= PS_DISCARD;
                     end else if (pos_q == 4'(TIME_CHARS - 1)) begin
                        st_q  <= PS_FIELDS;
                        pos_q <= '0;
                     end else begin
                        pos_q <= pos_q + 4'd1;
                     end
                  end
                  PS_FIELDS: begin
                     if (in_data == CH_STAR) st_q <= PS_SUM_HI;
                     else                    xsum_q <= xsum_q ^ in_data;
                  end
                  PS_SUM_HI: begin
                     if (hex_ok) begin
                        sum_hi_q <= hex_nib;
                        st_q     <= PS_SUM_LO;
                     end else begin
                        err_q <= 1'b1;
                        st_q  <= PS_DISCARD;
                     end
                  end
                  PS_SUM_LO: begin
                     if (hex_ok) begin
                        sum_lo_q <= hex_nib;
                        st_q     <= PS_EXP_CR;
                     end else begin
                        err_q <= 1'b1;
                        st_q  <= PS_DISCARD;
                     end
                  end
                  PS_EXP_CR: begin
                     st_q <= (in_data == CH_CR) ? PS_EXP_LF : PS_DISCARD;
                  end
                  PS_EXP_LF: begin
                     if (in_data == CH_LF) begin
                        st_q  <= PS_IDLE;
                        tv_q  <= commit;
                        err_q <= !commit;
                     end else begin
                        st_q <= PS_DISCARD;
                     end
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   assign time_valid = tv_q;
   assign cksum_err  = err_q;
endmodule

// File: rtl/gga_time_extractor_chk.sv
module gga_time_extractor_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [7:0]  in_data,
   input logic        in_valid,
   input logic [7:0]  time_hh,
   input logic [7:0]  time_mm,
   input logic [7:0]  time_ss,
   input logic [11:0] time_ms,
   input logic        time_valid,
   input logic        cksum_err
);
   // R12
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(time_valid && cksum_err));

   // R12
   valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      time_valid |=> !time_valid);

   // R2
   valid_after_lf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      time_valid |-> $past(in_valid && (in_data == 8'h0A)));

   // R2
   time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !($stable(time_hh) && $stable(time_mm) && $stable(time_ss) && $stable(time_ms))
      |-> time_valid);

   // R2
   bcd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      time_valid |-> (time_hh[3:0] <= 4'd9) && (time_hh[7:4] <= 4'd9) &&
                     (time_mm[3:0] <= 4'd9) && (time_mm[7:4] <= 4'd9) &&
                     (time_ss[3:0] <= 4'd9) && (time_ss[7:4] <= 4'd9) &&
                     (time_ms[3:0] <= 4'd9) && (time_ms[7:4] <= 4'd9) &&
                     (time_ms[11:8] <= 4'd9));

   // R3
   err_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cksum_err |-> $past(in_valid));
endmodule

bind gga_time_extractor gga_time_extractor_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_data   (in_data),
   .in_valid  (in_valid),
   .time_hh   (time_hh),
   .time_mm   (time_mm),
   .time_ss   (time_ss),
   .time_ms   (time_ms),
   .time_valid(time_valid),
   .cksum_err (cksum_err)
);

// File: tb/sim_gga_time_extractor.sv
module sim_gga_time_extractor;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  in_data = 8'h00;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [7:0]  time_hh, time_mm, time_ss;
   logic [11:0] time_ms;
   logic        time_valid, cksum_err;

   int checks = 0, errors = 0;
   int tv_seen = 0, err_seen = 0, both_seen = 0;
   bit done = 1'b0;
   logic [7:0]  e_hh = '0, e_mm = '0, e_ss = '0;
   logic [11:0] e_ms = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gga_time_extractor u0 (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
      .in_ready(in_ready), .time_hh(time_hh), .time_mm(time_mm),
      .time_ss(time_ss), .time_ms(time_ms), .time_valid(time_valid),
      .cksum_err(cksum_err)
   );

   always @(negedge clk) if (rst_n) begin
      if (time_valid) tv_seen++;
      if (cksum_err) err_seen++;
      if (time_valid && cksum_err) both_seen++;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_time(input string req);
      chk({time_hh, time_mm, time_ss, time_ms} == {e_hh, e_mm, e_ss, e_ms}, req,
          {time_hh, time_mm, time_ss, time_ms[11:4]},
          {e_hh, e_mm, e_ss, e_ms[11:4]});
      chk(time_ms == e_ms, req, 32'(time_ms), 32'(e_ms));
   endtask

   // R11: between bytes in_valid is low while '$' sits on the data lines
   task automatic send_byte(input logic [7:0] b);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = b;
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 8'h24;
   endtask

   task automatic send_str(input string s);
      for (int i = 0; i < s.len(); i++) send_byte(s[i]);
   endtask

   function automatic logic [7:0] xsum(input string s);
      logic [7:0] x = 8'h00;
      for (int i = 0; i < s.len(); i++) x ^= s[i];
      return x;
   endfunction

   function automatic string hex2(input logic [7:0] v, input bit lower);
      return lower ? $sformatf("%02x", v) : $sformatf("%02X", v);
   endfunction

   function automatic string gga_body(input int hh, mm, ss, ms);
      return $sformatf("GPGGA,%02d%02d%02d.%03d,4807.038,N,01131.000,E,1,08,0.9,545.4,M,46.9,M,,",
                       hh, mm, ss, ms);
   endfunction

   function automatic logic [7:0] bcd2(input int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   // full sentence; checks strobes and time right after the LF edge
   task automatic send_gga(input int hh, mm, ss, ms, input bit lower, input bit bad);
      string b;
      logic [7:0] ck;
      b  = gga_body(hh, mm, ss, ms);
      ck = xsum(b) ^ (bad ? 8'h5A : 8'h00);
      send_str({"$", b, "*", hex2(ck, lower), "\r\n"});
      if (!bad) begin
         e_hh = bcd2(hh); e_mm = bcd2(mm); e_ss = bcd2(ss);
         e_ms = 12'(((ms / 100) << 8) | (((ms / 10) % 10) << 4) | (ms % 10));
         chk(time_valid == 1'b1, lower ? "R4 valid strobe" : "R2 valid strobe",
             32'(time_valid), 32'd1);
         chk(cksum_err == 1'b0, "R12 no err with valid", 32'(cksum_err), 32'd0);
         chk_time("R2 time fields");
         @(negedge clk);
         chk(time_valid == 1'b0, "R12 single cycle", 32'(time_valid), 32'd0);
      end else begin
         chk(cksum_err == 1'b1, "R3 mismatch err", 32'(cksum_err), 32'd1);
         chk(time_valid == 1'b0, "R3 no valid", 32'(time_valid), 32'd0);
         chk_time("R3 time kept");
      end
   endtask

   task automatic send_silent(input string body, input string req);
      int tv0, er0;
      tv0 = tv_seen; er0 = err_seen;
      send_str({"$", body, "*", hex2(xsum(body), 1'b0), "\r\n"});
      repeat (2) @(negedge clk);
      chk(tv_seen == tv0, req, 32'(tv_seen - tv0), 32'd0);
      chk(err_seen == er0, req, 32'(err_seen - er0), 32'd0);
      chk_time(req);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      string b;
      int tv0, er0;
      repeat (3) @(negedge clk);
      // R1
      chk({time_hh, time_mm, time_ss, time_ms, time_valid, cksum_err} == '0,
          "R1 reset outputs", {time_hh, time_mm, time_ss, time_ms[11:4]}, 32'd0);
      chk(in_ready == 1'b1, "R1 ready", 32'(in_ready), 32'd1);
      rst_n = 1'b1;
      @(negedge clk);
      chk({time_hh, time_mm, time_ss, time_ms, time_valid, cksum_err} == '0,
          "R1 after release", {time_hh, time_mm, time_ss, time_ms[11:4]}, 32'd0);

      // R2 R4 R11 sweep
      for (int i = 0; i < 40; i++)
         send_gga(i % 24, (i * 7) % 60, (i * 13) % 60, (i * 37 + 5) % 1000, i[0], 1'b0);
      send_gga(23, 59, 59, 999, 1'b0, 1'b0);
      send_gga(0, 0, 0, 0, 1'b1, 1'b0);

      // R3
      send_gga(12, 35, 19, 354, 1'b0, 1'b1);
      send_gga(12, 35, 19, 354, 1'b1, 1'b1);

      // R5: non-hex in each checksum position
      b = gga_body(1, 2, 3, 4);
      send_str({"$", b, "*"});
      send_byte("G");
      chk(cksum_err == 1'b1, "R5 bad hex hi", 32'(cksum_err), 32'd1);
      send_str("7\r\n");
      send_str({"$", b, "*3"});
      send_byte("z");
      chk(cksum_err == 1'b1, "R5 bad hex lo", 32'(cksum_err), 32'd1);
      send_str("\r\n");
      @(negedge clk);
      chk_time("R5 time kept");

      // R6
      send_silent("GPRMC,010203.004,A,,", "R6 other type");
      send_silent("GPGGB,010203.004,,", "R6 near miss");
      send_silent("GPGGAX,010203.004,,", "R6 long id");
      send_silent("GNGGA,010203.004,,", "R6 other talker");

      // R7
      send_silent("GPGGA,01a203.004,,", "R7 letter in hours");
      send_silent("GPGGA,010203,004,,", "R7 no dot");
      send_silent("GPGGA,010203.0x4,,", "R7 letter in ms");
      send_silent("GPGGA,,,", "R7 empty field");

      // R10
      b = gga_body(4, 5, 6, 7);
      tv0 = tv_seen; er0 = err_seen;
      send_str({"$", b, "*", hex2(xsum(b), 1'b0), "X\r\n"});
      send_str({"$", b, "*", hex2(xsum(b), 1'b0), "\n"});
      repeat (2) @(negedge clk);
      chk(tv_seen == tv0 && err_seen == er0, "R10 unterminated",
          32'(tv_seen - tv0 + err_seen - er0), 32'd0);

      // R8
      send_str("$GPGGA,0102");
      send_gga(9, 8, 7, 65, 1'b0, 1'b0);
      send_str("$GPGGA,112233.444,1,2*");
      send_gga(10, 20, 30, 405, 1'b1, 1'b0);

      // R9: 82 characters accepted, 83rd raises the error
      b = gga_body(2, 2, 2, 2);
      while (b.len() < 95) b = {b, "A"};
      tv0 = tv_seen; er0 = err_seen;
      send_byte("$");
      for (int i = 0; i < 81; i++) send_byte(b[i]);
      chk(err_seen == er0, "R9 82 chars ok", 32'(err_seen - er0), 32'd0);
      send_byte(b[81]);
      chk(cksum_err == 1'b1, "R9 83rd char err", 32'(cksum_err), 32'd1);
      for (int i = 82; i < b.len(); i++) send_byte(b[i]);
      send_str({"*", hex2(xsum(b), 1'b0), "\r\n"});
      repeat (2) @(negedge clk);
      chk(tv_seen == tv0 && err_seen == er0 + 1, "R9 dropped",
          32'(tv_seen - tv0 + err_seen - er0), 32'd1);
      chk_time("R9 time kept");
      // R9: a sentence exactly 82 long decodes
      b = gga_body(3, 4, 5, 6);
      while (b.len() < 82 - 6) b = {b, "B"};
      send_gga_body_exact(b);

      // R12
      chk(both_seen == 0, "R12 never both", 32'(both_seen), 32'd0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   task automatic send_gga_body_exact(input string b);
      send_str({"$", b, "*", hex2(xsum(b), 1'b0), "\r\n"});
      e_hh = 8'h03; e_mm = 8'h04; e_ss = 8'h05; e_ms = 12'h006;
      chk(time_valid == 1'b1, "R9 exactly 82 chars", 32'(time_valid), 32'd1);
      chk_time("R9 exact time");
   endtask
endmodule